// File: doc/BRIEF.md
# Robbed-Bit Signaling Re-insertion Unit

This unit writes robbed-bit signaling into a serial 24-channel T1 PCM stream, one bit per clock. A serial signaling stream runs beside the data stream bit for bit. In each channel slot that stream carries the A, B, C and D bits in the last four bit positions of the slot. The user supplies a multiframe sync pulse. From the time of that pulse the unit counts frames, slots and bits, and in each signaling frame it overwrites the least significant bit of each selected channel with the matching signaling letter. Both D4 (12-frame) and ESF (24-frame) multiframes are supported. Two backplane formats are supported: 193-bit frames at 1.544 MHz and 256-bit frames at 2.048 MHz.

A per-channel block flag can exclude channels from re-insertion. The flag is sampled at the first bit of each slot. A separate option writes ones in place of the signaling letters, and it obeys the same block flag. Every output bit, whether it was replaced or not, leaves the unit exactly one clock after it entered.

Top module: `rbs_reinsert`

## Requirements
- R1: With `reinsertEn` low, `serOut` equals `serIn` of the previous clock for every bit.
- R2: Every bit that is not a replaced signaling bit appears on `serOut` one clock after it was on `serIn`, unchanged.
- R3: In D4 mode (`esfMode`=0) the last bit of each channel slot (slot bit 7, where bit 0 is sent first) in frame 6 becomes the A bit and in frame 12 becomes the B bit. A is `sigIn` at slot bit 4 of the same slot and B is `sigIn` at slot bit 5.
- R4: In ESF mode (`esfMode`=1) slot bit 7 of each channel in frames 6, 12, 18 and 24 becomes A, B, C and D. These are `sigIn` at slot bits 4, 5, 6 and 7 of the same slot.
- R5: A high `mfSync` marks the first bit of frame 1. In the 193-bit format that bit is the framing bit; in the 256-bit format it is bit 0 of slot 0. No bit is replaced before the first `mfSync`, and every later pulse realigns the count.
- R6: With `perChanEn` high, a channel whose `blockFlag` was high at slot bit 0 passes unchanged. The value of `blockFlag` at slot bits 1 to 7 has no effect.
- R7: With `perChanEn` low, all 24 channels receive signaling whatever the value of `blockFlag`.
- R8: With `forceOnes` high, each bit that would be replaced becomes 1 instead of the signaling letter. Blocked channels still pass unchanged.
- R9: With `wideFormat` high (256-bit frames), slots 1 to 24 carry channels 1 to 24. Slot 0 and slots 25 to 31 pass unchanged.
- R10: While `rstN` is low, `serOut` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rstN | input | 1 | Asynchronous active-low reset |
| serIn | input | 1 | Serial PCM data in |
| sigIn | input | 1 | Serial signaling in, aligned with serIn |
| mfSync | input | 1 | Multiframe sync, high on the first bit of frame 1 |
| blockFlag | input | 1 | Per-channel block flag, sampled at slot bit 0 |
| reinsertEn | input | 1 | Global re-insertion enable |
| perChanEn | input | 1 | Lets blockFlag exclude channels |
| forceOnes | input | 1 | Replaces the signaling letters with ones |
| esfMode | input | 1 | 1 = 24-frame ESF, 0 = 12-frame D4 |
| wideFormat | input | 1 | 1 = 256-bit frames, 0 = 193-bit frames |
| serOut | output | 1 | Serial PCM data out, one clock late |

## Verification
The bench drives `blockFlag` at slot bits 1 to 7 to the opposite of its value at slot bit 0. A design that samples the flag at the wrong time, or does not hold it, therefore blocks the wrong channels. It cuts one multiframe short after 7 frames and then resyncs, so a counter that ignores a second pulse puts the signaling in the wrong frames. Each run also checks the framing bit and the unused wide slots, where an off-by-one slot decode would corrupt data. It checks the letter order in ESF frames 18 and 24, where an error in letter selection would write A or B where C or D belongs. A pre-sync run with the enable set checks that nothing is replaced before the first `mfSync`.

// File: rtl/rbs_pkg.sv
package rbs_pkg;
  // Number of signaling letters in the longest multiframe (A, B, C, D)
  localparam int SIG_LETTERS = 4;
  localparam int SEL_W = $clog2(SIG_LETTERS);

  // Strobes from the frame controller to the bit datapath
  typedef struct packed {
    logic             sampleBlk;  // slot bit 0 of a channel slot
    logic             capA;       // slot bit carrying A
    logic             capB;       // slot bit carrying B
    logic             capC;       // slot bit carrying C
    logic             replace;    // this bit is a signaling position to overwrite
    logic [SEL_W-1:0] sigSel;     // which letter belongs to this frame
  } rbsStrobe_t;
endpackage

// File: rtl/rbs_frame_ctrl.sv
module rbs_frame_ctrl
  import rbs_pkg::*;
#(
  parameter int CHANNELS   = 24,
  parameter int SLOT_BITS  = 8,
  parameter int WIDE_SLOTS = 32,
  parameter int D4_FRAMES  = 12,
  parameter int ESF_FRAMES = 24,
  parameter int SIG_PERIOD = 6
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       mfSync,
  input  logic       reinsertEn,
  input  logic       esfMode,
  input  logic       wideFormat,
  output rbsStrobe_t strb
);
  localparam int SLOT_W  = $clog2(WIDE_SLOTS);
  localparam int BIT_W   = $clog2(SLOT_BITS);
  localparam int FRAME_W = $clog2(ESF_FRAMES);
  localparam int SIG_FRAMES = ESF_FRAMES / SIG_PERIOD;

  logic               inFReg, curInF, nInF;
  logic [SLOT_W-1:0]  slotReg, curSlot, nSlot, lastSlot;
  logic [BIT_W-1:0]   bitReg, curBit, nBit;
  logic [FRAME_W-1:0] frameReg, curFrame, nFrame, lastFrame;
  logic               syncedReg;
  logic               chanSlot, sigFrame;
  logic [SEL_W-1:0]   sigIdx;

  // A sync pulse puts the current bit at the start of frame 1
  always_comb begin
    curInF   = mfSync ? !wideFormat : inFReg;
    curSlot  = mfSync ? '0 : slotReg;
    curBit   = mfSync ? '0 : bitReg;
    curFrame = mfSync ? '0 : frameReg;
    lastSlot  = wideFormat ? SLOT_W'(WIDE_SLOTS - 1) : SLOT_W'(CHANNELS - 1);
    lastFrame = esfMode ? FRAME_W'(ESF_FRAMES - 1) : FRAME_W'(D4_FRAMES - 1);
  end

  always_comb begin
    nInF   = curInF;
    nSlot  = curSlot;
    nBit   = curBit;
    nFrame = curFrame;
    if (curInF) begin
      nInF  = 1'b0;
      nSlot = '0;
      nBit  = '0;
    end else if (curBit == BIT_W'(SLOT_BITS - 1)) begin
      nBit = '0;
      if (curSlot >= lastSlot) begin
        nSlot  = '0;
        nInF   = !wideFormat;
        nFrame = (curFrame >= lastFrame) ? '0 : curFrame + 1'b1;
      end else begin
        nSlot = curSlot + 1'b1;
      end
    end else begin
      nBit = curBit + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inFReg    <= 1'b1;
      slotReg   <= '0;
      bitReg    <= '0;
      frameReg  <= '0;
      syncedReg <= 1'b0;
    end else begin
      inFReg    <= nInF;
      slotReg   <= nSlot;
      bitReg    <= nBit;
      frameReg  <= nFrame;
      syncedReg <= syncedReg | mfSync;
    end
  end

  // Signaling frames are the last frame of each SIG_PERIOD group
  always_comb begin
    sigFrame = 1'b0;
    sigIdx   = '0;
    for (int k = 0; k < SIG_FRAMES; k++) begin
      if (curFrame == FRAME_W'((k + 1) * SIG_PERIOD - 1)) begin
        sigFrame = 1'b1;
        sigIdx   = SEL_W'(k);
      end
    end
  end

  generate
    if (WIDE_SLOTS > CHANNELS) begin : g_wideMap
      always_comb
        chanSlot = !curInF &&
                   (!wideFormat || (curSlot >= SLOT_W'(1) && curSlot <= SLOT_W'(CHANNELS)));
    end else begin : g_narrowMap
      always_comb chanSlot = !curInF;
    end
  endgenerate

  always_comb begin
    strb.sampleBlk = chanSlot && (curBit == '0);
    strb.capA      = chanSlot && (curBit == BIT_W'(SLOT_BITS - 4));
    strb.capB      = chanSlot && (curBit == BIT_W'(SLOT_BITS - 3));
    strb.capC      = chanSlot && (curBit == BIT_W'(SLOT_BITS - 2));
    strb.replace   = chanSlot && (curBit == BIT_W'(SLOT_BITS - 1)) && sigFrame &&
                     reinsertEn && (syncedReg || mfSync);
    strb.sigSel    = sigIdx;
  end
endmodule

// File: rtl/rbs_bit_path.sv
module rbs_bit_path
  import rbs_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  rbsStrobe_t strb,
  input  logic       serIn,
  input  logic       sigIn,
  input  logic       blockFlag,
  input  logic       perChanEn,
  input  logic       forceOnes,
  output logic       chanBlocked,
  output logic       serOut
);
  logic [SIG_LETTERS-2:0] sigNib;
  logic sigBit, insBit, doIns, nextOut;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chanBlocked <= 1'b0;
      sigNib      <= '0;
      serOut      <= 1'b0;
    end else begin
      if (strb.sampleBlk) chanBlocked <= blockFlag;
      if (strb.capA)      sigNib[0]   <= sigIn;
      if (strb.capB)      sigNib[1]   <= sigIn;
      if (strb.capC)      sigNib[2]   <= sigIn;
      serOut <= nextOut;
    end
  end

  always_comb begin
    case (strb.sigSel)
      SEL_W'(0): sigBit = sigNib[0];
      SEL_W'(1): sigBit = sigNib[1];
      SEL_W'(2): sigBit = sigNib[2];
      default:   sigBit = sigIn;
    endcase
    insBit  = forceOnes ? 1'b1 : sigBit;
    doIns   = strb.replace && !(perChanEn && chanBlocked);
    nextOut = doIns ? insBit : serIn;
  end
endmodule

// File: rtl/rbs_reinsert.sv
module rbs_reinsert
  import rbs_pkg::*;
#(
  parameter int CHANNELS   = 24,
  parameter int SLOT_BITS  = 8,
  parameter int WIDE_SLOTS = 32,
  parameter int D4_FRAMES  = 12,
  parameter int ESF_FRAMES = 24,
  parameter int SIG_PERIOD = 6
) (
  input  logic clk,
  input  logic rstN,
  input  logic serIn,
  input  logic sigIn,
  input  logic mfSync,
  input  logic blockFlag,
  input  logic reinsertEn,
  input  logic perChanEn,
  input  logic forceOnes,
  input  logic esfMode,
  input  logic wideFormat,
  output logic serOut
);
  rbsStrobe_t strb;
  logic       chanBlocked;

  rbs_frame_ctrl #(
    .CHANNELS(CHANNELS), .SLOT_BITS(SLOT_BITS), .WIDE_SLOTS(WIDE_SLOTS),
    .D4_FRAMES(D4_FRAMES), .ESF_FRAMES(ESF_FRAMES), .SIG_PERIOD(SIG_PERIOD)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .mfSync(mfSync), .reinsertEn(reinsertEn),
    .esfMode(esfMode), .wideFormat(wideFormat), .strb(strb)
  );

  rbs_bit_path u_path (
    .clk(clk), .rstN(rstN), .strb(strb), .serIn(serIn), .sigIn(sigIn),
    .blockFlag(blockFlag), .perChanEn(perChanEn), .forceOnes(forceOnes),
    .chanBlocked(chanBlocked), .serOut(serOut)
  );
endmodule

// File: rtl/rbs_reinsert_chk.sv
module rbs_reinsert_chk
  import rbs_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       serIn,
  input logic       serOut,
  input logic       mfSync,
  input logic       reinsertEn,
  input logic       perChanEn,
  input logic       forceOnes,
  input rbsStrobe_t strb,
  input logic       chanBlocked
);
  logic seenSync;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) seenSync <= 1'b0;
    else if (mfSync) seenSync <= 1'b1;
  end

  AST_IDLE_PASS: assert property (@(posedge clk) disable iff (!rstN)
    !reinsertEn |=> serOut == $past(serIn)); // R1
  AST_PLAIN_BIT_DELAY: assert property (@(posedge clk) disable iff (!rstN)
    !strb.replace |=> serOut == $past(serIn)); // R2
  AST_STROBE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.sampleBlk, strb.capA, strb.capB, strb.capC, strb.replace})); // R3
  AST_NO_EARLY_INSERT: assert property (@(posedge clk) disable iff (!rstN)
    (!seenSync && !mfSync) |-> !strb.replace); // R5
  AST_BLOCKED_CHANNEL: assert property (@(posedge clk) disable iff (!rstN)
    (strb.replace && perChanEn && chanBlocked) |=> serOut == $past(serIn)); // R6
  AST_FORCED_ONE: assert property (@(posedge clk) disable iff (!rstN)
    (strb.replace && forceOnes && !(perChanEn && chanBlocked)) |=> serOut); // R8
  AST_RESET_LOW: assert property (@(posedge clk)
    !rstN |-> !serOut); // R10
endmodule

bind rbs_reinsert rbs_reinsert_chk u_chk (
  .clk(clk), .rstN(rstN), .serIn(serIn), .serOut(serOut), .mfSync(mfSync),
  .reinsertEn(reinsertEn), .perChanEn(perChanEn), .forceOnes(forceOnes),
  .strb(strb), .chanBlocked(chanBlocked)
);

// File: tb/rbs_reinsert_bench.sv
module rbs_reinsert_bench;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rstN, serIn, sigIn, mfSync, blockFlag;
  logic reinsertEn, perChanEn, forceOnes, esfMode, wideFormat, serOut;
  // configuration applied together with the next driven bit
  bit pEn, pPer, pFrc, pEsf, pWide;

  int checks = 0;
  int fails  = 0;
  bit    expQ[$];
  string tagQ[$];

  rbs_reinsert u_rbs_reinsert (
    .clk(clk), .rstN(rstN), .serIn(serIn), .sigIn(sigIn), .mfSync(mfSync),
    .blockFlag(blockFlag), .reinsertEn(reinsertEn), .perChanEn(perChanEn),
    .forceOnes(forceOnes), .esfMode(esfMode), .wideFormat(wideFormat),
    .serOut(serOut)
  );

  task automatic check(input logic got, input bit exp, input string tag);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: serOut=%b expected=%0b at %0t", tag, got, exp, $time);
    end
  endtask

  // monitor: pops one expected bit per clock after each edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (expQ.size() > 0) begin
        bit e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check(serOut, e, t);
      end
    end
  end

  task automatic driveBit(input logic d, input logic s, input logic b, input logic sy,
                          input bit exp, input string tag, input bit push);
    @(negedge clk);
    serIn = d; sigIn = s; blockFlag = b; mfSync = sy;
    reinsertEn = pEn; perChanEn = pPer; forceOnes = pFrc;
    esfMode = pEsf; wideFormat = pWide;
    if (push) begin
      expQ.push_back(exp);
      tagQ.push_back(tag);
    end
  endtask

  // Drives nFrames frames and predicts every output bit
  task automatic runMf(input int nFrames, input bit esf, input bit wide, input bit en,
                       input bit per, input bit frc, input bit doSync,
                       input bit dutSynced, input bit alignTag, input logic [23:0] mask);
    bit nib[4];
    pEn = en; pPer = per; pFrc = frc; pEsf = esf; pWide = wide;
    for (int fr = 0; fr < nFrames; fr++) begin
      int total = wide ? 256 : 193;
      for (int i = 0; i < total; i++) begin
        int ch, pos;
        logic d, s, b, sy;
        bit exp, sigFr;
        string tag;
        if (wide) begin
          pos = i % 8;
          ch = (i / 8 >= 1 && i / 8 <= 24) ? i / 8 - 1 : -1;
        end else begin
          ch  = (i == 0) ? -1 : (i - 1) / 8;
          pos = (i == 0) ? 0 : (i - 1) % 8;
        end
        d = 1'($urandom);
        s = 1'($urandom);
        // block flag: true value at slot bit 0, inverted elsewhere (R6)
        if (ch >= 0) b = (pos == 0) ? mask[ch] : !mask[ch];
        else b = 1'($urandom);
        if (ch >= 0 && pos >= 4) nib[pos - 4] = s;
        sy = doSync && fr == 0 && i == 0;
        sigFr = esf ? (fr % 6 == 5) : (fr == 5 || fr == 11);
        exp = d;
        tag = !en ? "R1" : ((wide && ch < 0) ? "R9" : "R2");
        if (en && ch >= 0 && pos == 7 && sigFr) begin
          if (!dutSynced) tag = "R5";
          else if (per && mask[ch]) tag = "R6";
          else begin
            exp = frc ? 1'b1 : nib[fr / 6];
            if (alignTag) tag = "R5";
            else if (frc) tag = "R8";
            else if (!per && mask[ch]) tag = "R7";
            else tag = esf ? "R4" : "R3";
          end
        end
        driveBit(d, s, b, sy, exp, tag, 1'b1);
      end
    end
  endtask

  initial begin
    rstN = 1'b0;
    serIn = 0; sigIn = 0; mfSync = 0; blockFlag = 0;
    reinsertEn = 0; perChanEn = 0; forceOnes = 0; esfMode = 0; wideFormat = 0;
    serIn = 1'b1;
    repeat (3) @(posedge clk);
    #2;
    check(serOut, 1'b0, "R10"); // reset holds output low even with serIn high
    @(negedge clk);
    rstN = 1'b1;

    // R5: enabled but no sync yet, nothing replaced
    runMf(12, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 24'h0);
    // R3 / R7: D4 narrow, all channels despite flags
    runMf(12, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 24'hA5_0F_33);
    // R4 / R6: ESF narrow, per-channel control
    runMf(24, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 24'h5A_3C_81);
    // R5: short multiframe then a resync realigns the count
    runMf(7, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 24'h0);
    runMf(24, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 24'h0);
    // R8: forced ones with blocking in D4
    runMf(12, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 24'hC3_18_E7);
    // R9: wide format, ESF
    runMf(24, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 24'h0);
    // R9 / R8: wide format, D4, forced ones with blocking
    runMf(12, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 24'h81_42_24);
    // R1: enable off in ESF
    runMf(24, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 24'h0);

    pEn = 1'b0;
    repeat (4) driveBit(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R2", 1'b0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog: run hung, actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule